// File: doc/BRIEF.md
# Double-Buffered Memory Timing Register Bank

This block holds the timing and configuration words for an external memory interface. Each word has two copies. The shadow copy is the one software programs over a simple register bus. The active copy is the one the memory interface actually uses. A new timing set is written into the shadows one word at a time. All the words then switch over in a single clock edge, so the memory interface never runs with a half-updated set.

The switch-over happens in one of two ways. The first is a clock-change handshake with an external clock generator. The generator raises a request. The block copies the shadows and acknowledges on the same edge, and it records completion in an interrupt status register. The second is a manual flush written by software. The handshake answers only when software has enabled it. While the acknowledge is high, one of two outputs tells the memory interface whether to park the DRAM in power-down or in self-refresh.

An overflow input for refresh requests also feeds the status register. The status register is write-one-to-clear, and a mask register selects which status bits drive the interrupt line.

Top module: `timing_shadow_bank`

## Requirements
- R1: After reset, every shadow and active word is 0, and the status, mask and config registers read 0. The acknowledge, interrupt and both suspend outputs are low.
- R2: A bus write to byte address 0x100 + 4*i (i from 0 to NUM_REGS-1) stores the data in shadow word i. A read of that address returns the shadow word. The active word does not change until an update event occurs.
- R3: A write to address 0x028 with data bit 0 set copies every shadow word into its active word on that edge. A write to 0x028 with bit 0 clear copies nothing. Address 0x028 reads 0, and a manual flush does not set status bit 4.
- R4: When config bit 0 is 1, a request seen while the acknowledge is low completes a handshake on that edge. The acknowledge rises, every active word is loaded from its shadow, and status bit 4 is set. The acknowledge then stays high while the request stays high, and it falls on the first edge at which the request is low.
- R5: When config bit 0 (config register at 0x2b8) is 0, the request is ignored. The acknowledge stays low, the active words keep their values and status bit 4 is not set.
- R6: When a handshake completion and a manual flush fall in the same cycle, a single copy takes place. When a shadow write falls in the same cycle as a copy, the active word receives the shadow value from before that write.
- R7: The status register at 0x000 is write-one-to-clear. Writing 1 to bit 3 or bit 4 clears that bit, and writing 0 leaves it unchanged. If a set event arrives in the same cycle as the clear, the set wins.
- R8: A high level on the refresh-overflow input sets status bit 3.
- R9: The mask register at 0x004 holds bit 3 and bit 4 and reads back only those bits. The interrupt output is high exactly when some status bit is 1 and its mask bit is 1.
- R10: While the acknowledge is high, the outputs depend on config bits 2 and 1 (register 0x2b8). The power-down output is high when bit 1 is set and bit 2 is clear. The self-refresh output is high when bit 2 is set, so self-refresh has priority over power-down. Both outputs are low while the acknowledge is low.
- R11: The config register at 0x2b8 reads back bits 2:0. Any unmapped address reads 0, and writes to unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W (12) | Byte address of the register access |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data for busAddr (combinational) |
| clkChgReq | input | 1 | Clock-change request from the clock generator |
| clkChgAck | output | 1 | Clock-change acknowledge |
| refreshOverflow | input | 1 | Refresh-request overflow event |
| irq | output | 1 | Masked interrupt request |
| dramPowerDown | output | 1 | Park the DRAM in power-down during the change |
| dramSelfRefresh | output | 1 | Park the DRAM in self-refresh during the change |
| activeTiming | output | NUM_REGS*DATA_W (1472) | Active timing words, word i at bits i*DATA_W and up |

## Verification
The tests first write the shadows with distinct patterns while no update event occurs. Frozen active words then separate shadow storage from active storage.

Both update paths are tested on their own, and each is checked for whether it sets the completion status bit. The handshake request is also driven with the enable cleared, and with the enable set but no flush, which separates the enable gate from the copy logic.

Several events are placed in the same cycle: a request together with a shadow write, a request together with a flush, and an overflow together with its own clear. These cases expose which copy ordering and which set-versus-clear priority the design uses.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam logic [11:0] OFS_STATUS = 12'h000;
  localparam logic [11:0] OFS_MASK   = 12'h004;
  localparam logic [11:0] OFS_UPDATE = 12'h028;
  localparam logic [11:0] OFS_CONFIG = 12'h2b8;

  localparam int BIT_REFOV   = 3;
  localparam int BIT_CLKDONE = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic shadowWe;
    logic copyAll;
  } tsb_strobe_t;
endpackage

// File: rtl/tsb_datapath.sv
module tsb_datapath #(
  parameter int NUM_REGS = 46,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tsb_pkg::tsb_strobe_t       strobe,
  input  logic [IDX_W-1:0]           regIdx,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          shadowRdata,
  output logic [NUM_REGS*DATA_W-1:0] activeFlat
);
  logic [DATA_W-1:0]          shadowMem [NUM_REGS];
  logic [NUM_REGS*DATA_W-1:0] shadowFlat;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gWord
    logic [DATA_W-1:0] activeWord;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowMem[g] <= '0;
        activeWord   <= '0;
      end else begin
        if (strobe.shadowWe && regIdx == IDX_W'(g)) shadowMem[g] <= wrData;
        if (strobe.copyAll) activeWord <= shadowMem[g];
      end
    end

    assign activeFlat[g*DATA_W +: DATA_W] = activeWord;
    assign shadowFlat[g*DATA_W +: DATA_W] = shadowMem[g];
  end

  always_comb begin
    shadowRdata = '0;
    if (int'(regIdx) < NUM_REGS) shadowRdata = shadowMem[regIdx];
  end

  // R3 R4: an update loads every active word from the shadows seen before the edge
  assert_copy_loads_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.copyAll |=> activeFlat == $past(shadowFlat));

  // R2: without an update event the active words hold
  assert_active_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.copyAll |=> $stable(activeFlat));
endmodule

// File: rtl/tsb_control.sv
module tsb_control
  import tsb_pkg::*;
#(
  parameter int NUM_REGS    = 46,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int TIMING_BASE = 'h100,
  parameter int IDX_W       = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] shadowRdata,
  output logic [IDX_W-1:0]  regIdx,
  output tsb_strobe_t       strobe,
  input  logic              clkChgReq,
  output logic              clkChgAck,
  input  logic              refreshOverflow,
  output logic              irq,
  output logic              dramPowerDown,
  output logic              dramSelfRefresh
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(TIMING_BASE);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(TIMING_BASE + 4 * NUM_REGS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] UPD_A  = ADDR_W'(OFS_UPDATE);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(OFS_CONFIG);

  logic              hitTiming;
  logic [ADDR_W-1:0] wordOfs;
  logic              hsDone;
  logic              manualUpd;
  logic [DATA_W-1:0] clrBits;
  logic              stRefOv, stClkDone;
  logic              mskRefOv, mskClkDone;
  logic [2:0]        cfgReg;
  logic              ackReg;

  // address decode
  assign hitTiming = (busAddr >= BASE_A) && (busAddr < END_A) && (busAddr[1:0] == 2'b00);
  assign wordOfs   = busAddr - BASE_A;
  assign regIdx    = wordOfs[IDX_W+1:2];

  // update triggers
  assign hsDone    = clkChgReq && cfgReg[0] && !ackReg;
  assign manualUpd = busWe && (busAddr == UPD_A) && busWdata[0];

  always_comb begin
    strobe          = '0;
    strobe.shadowWe = busWe && hitTiming;
    strobe.copyAll  = hsDone || manualUpd;
  end

  assign clrBits = (busWe && busAddr == STAT_A) ? busWdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stRefOv    <= 1'b0;
      stClkDone  <= 1'b0;
      mskRefOv   <= 1'b0;
      mskClkDone <= 1'b0;
      cfgReg     <= '0;
      ackReg     <= 1'b0;
    end else begin
      stRefOv   <= (stRefOv   && !clrBits[BIT_REFOV])   || refreshOverflow;
      stClkDone <= (stClkDone && !clrBits[BIT_CLKDONE]) || hsDone;
      if (busWe && busAddr == MASK_A) begin
        mskRefOv   <= busWdata[BIT_REFOV];
        mskClkDone <= busWdata[BIT_CLKDONE];
      end
      if (busWe && busAddr == CFG_A) cfgReg <= busWdata[2:0];
      if (!clkChgReq)  ackReg <= 1'b0;
      else if (hsDone) ackReg <= 1'b1;
    end
  end

  assign clkChgAck       = ackReg;
  assign irq             = (stRefOv && mskRefOv) || (stClkDone && mskClkDone);
  assign dramPowerDown   = ackReg && cfgReg[1] && !cfgReg[2];
  assign dramSelfRefresh = ackReg && cfgReg[2];

  // read mux
  always_comb begin
    busRdata = '0;
    if (hitTiming) busRdata = shadowRdata;
    else if (busAddr == STAT_A) begin
      busRdata[BIT_REFOV]   = stRefOv;
      busRdata[BIT_CLKDONE] = stClkDone;
    end else if (busAddr == MASK_A) begin
      busRdata[BIT_REFOV]   = mskRefOv;
      busRdata[BIT_CLKDONE] = mskClkDone;
    end else if (busAddr == CFG_A) busRdata[2:0] = cfgReg;
  end

  // R5: the acknowledge cannot rise unless the handshake is enabled
  assert_ack_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!clkChgAck && !(clkChgReq && cfgReg[0])) |=> !clkChgAck);

  // R4: the acknowledge falls once the request has gone
  assert_ack_follows_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    !clkChgReq |=> !clkChgAck);

  // R4: a completed handshake leaves the completion status set
  assert_done_sets_status_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clkChgReq && cfgReg[0] && !clkChgAck) |=> stClkDone);

  // R10: never both suspend modes at once
  assert_suspend_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dramPowerDown, dramSelfRefresh}));

  // R9: no interrupt without a pending status bit
  assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!stRefOv && !stClkDone) |-> !irq);
endmodule

// File: rtl/timing_shadow_bank.sv
module timing_shadow_bank #(
  parameter int NUM_REGS    = 46,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int TIMING_BASE = 'h100
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWe,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  input  logic                       clkChgReq,
  output logic                       clkChgAck,
  input  logic                       refreshOverflow,
  output logic                       irq,
  output logic                       dramPowerDown,
  output logic                       dramSelfRefresh,
  output logic [NUM_REGS*DATA_W-1:0] activeTiming
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  tsb_pkg::tsb_strobe_t strobe;
  logic [IDX_W-1:0]     regIdx;
  logic [DATA_W-1:0]    shadowRdata;

  tsb_control #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .TIMING_BASE(TIMING_BASE), .IDX_W(IDX_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .shadowRdata(shadowRdata), .regIdx(regIdx), .strobe(strobe),
    .clkChgReq(clkChgReq), .clkChgAck(clkChgAck),
    .refreshOverflow(refreshOverflow), .irq(irq),
    .dramPowerDown(dramPowerDown), .dramSelfRefresh(dramSelfRefresh)
  );

  tsb_datapath #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regIdx(regIdx),
    .wrData(busWdata), .shadowRdata(shadowRdata), .activeFlat(activeTiming)
  );
endmodule

// File: tb/sim_timing_shadow_bank.sv
module sim_timing_shadow_bank;
  localparam int PERIOD = 10;
  localparam int NREG   = 46;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic clkChgReq = 1'b0;
  logic clkChgAck;
  logic refreshOverflow = 1'b0;
  logic irq, dramPowerDown, dramSelfRefresh;
  logic [NREG*32-1:0] activeTiming;

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  timing_shadow_bank u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .clkChgReq(clkChgReq), .clkChgAck(clkChgAck),
    .refreshOverflow(refreshOverflow), .irq(irq), .dramPowerDown(dramPowerDown),
    .dramSelfRefresh(dramSelfRefresh), .activeTiming(activeTiming)
  );

  // behavioural reference model
  logic [31:0] mShadow [NREG];
  logic [31:0] mActive [NREG];
  bit mStRef, mStDone, mMskRef, mMskDone, mAck;
  bit [2:0] mCfg;

  function automatic int timingIndex(logic [11:0] a);
    int off = int'(a) - 256;
    if (off < 0 || off >= NREG * 4 || (off % 4) != 0) return -1;
    return off / 4;
  endfunction

  function automatic logic [31:0] modelRead(logic [11:0] a);
    logic [31:0] r = '0;
    int ix = timingIndex(a);
    if (ix >= 0) r = mShadow[ix];
    else if (a == 12'h000) begin r[3] = mStRef; r[4] = mStDone; end
    else if (a == 12'h004) begin r[3] = mMskRef; r[4] = mMskDone; end
    else if (a == 12'h2b8) r[2:0] = mCfg;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) begin mShadow[i] = '0; mActive[i] = '0; end
      mStRef = 0; mStDone = 0; mMskRef = 0; mMskDone = 0; mAck = 0; mCfg = '0;
    end else begin
      bit hs, cp;
      int ix;
      hs = clkChgReq && mCfg[0] && !mAck;
      cp = hs || (busWe && busAddr == 12'h028 && busWdata[0]);
      if (cp) for (int i = 0; i < NREG; i++) mActive[i] = mShadow[i];
      ix = timingIndex(busAddr);
      if (busWe && ix >= 0) mShadow[ix] = busWdata;
      if (busWe && busAddr == 12'h000) begin
        if (busWdata[3]) mStRef = 0;
        if (busWdata[4]) mStDone = 0;
      end
      if (refreshOverflow) mStRef = 1;
      if (hs) mStDone = 1;
      if (busWe && busAddr == 12'h004) begin mMskRef = busWdata[3]; mMskDone = busWdata[4]; end
      if (busWe && busAddr == 12'h2b8) mCfg = busWdata[2:0];
      if (!clkChgReq) mAck = 0; else if (hs) mAck = 1;
    end
    started = 1;
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      int bad = -1;
      chk(busRdata == modelRead(busAddr), "R2 R9 R11 read data", busRdata, modelRead(busAddr));
      chk(clkChgAck == mAck, "R4 acknowledge", 32'(clkChgAck), 32'(mAck));
      chk(irq == ((mStRef && mMskRef) || (mStDone && mMskDone)), "R9 irq", 32'(irq),
          32'((mStRef && mMskRef) || (mStDone && mMskDone)));
      chk(dramPowerDown == (mAck && mCfg[1] && !mCfg[2]), "R10 power-down",
          32'(dramPowerDown), 32'(mAck && mCfg[1] && !mCfg[2]));
      chk(dramSelfRefresh == (mAck && mCfg[2]), "R10 self-refresh",
          32'(dramSelfRefresh), 32'(mAck && mCfg[2]));
      for (int i = 0; i < NREG; i++)
        if (bad < 0 && activeTiming[i*32 +: 32] != mActive[i]) bad = i;
      if (bad < 0) chk(1'b1, "R2 R3 R4 active words", '0, '0);
      else chk(1'b0, "R2 R3 R4 active words", activeTiming[bad*32 +: 32], mActive[bad]);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    tick();
    busWe = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    busAddr = a; #1;
    chk(busRdata == exp, tag, busRdata, exp);
  endtask

  function automatic logic [31:0] act(int i);
    return activeTiming[i*32 +: 32];
  endfunction

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    rd(12'h000, 32'h0, "R1 status after reset");
    rd(12'h004, 32'h0, "R1 mask after reset");
    rd(12'h2b8, 32'h0, "R1 config after reset");
    rd(12'h100, 32'h0, "R1 shadow after reset");
    chk(activeTiming == '0, "R1 active after reset", act(0), 32'h0);
    chk({clkChgAck, irq, dramPowerDown, dramSelfRefresh} == 4'b0, "R1 outputs after reset",
        32'({clkChgAck, irq, dramPowerDown, dramSelfRefresh}), 32'h0);

    // R2 shadow writes stay staged
    for (int i = 0; i < NREG; i++) wr(12'(256 + 4 * i), 32'hA5000000 + 32'(i * 32'h01010));
    rd(12'h100, 32'hA5000000, "R2 shadow readback word 0");
    rd(12'h1b4, 32'hA5000000 + 32'(45 * 32'h01010), "R2 shadow readback last word");
    chk(act(0) == 32'h0 && act(45) == 32'h0, "R2 active unchanged by shadow write", act(45), 32'h0);

    // R3 manual flush
    wr(12'h028, 32'h0000_0002);
    chk(act(7) == 32'h0, "R3 flush with bit0 clear does nothing", act(7), 32'h0);
    wr(12'h028, 32'h0000_0001);
    chk(act(7) == 32'hA5000000 + 32'(7 * 32'h01010), "R3 flush copies shadows", act(7),
        32'hA5000000 + 32'(7 * 32'h01010));
    rd(12'h028, 32'h0, "R3 update register reads 0");
    rd(12'h000, 32'h0, "R3 flush leaves completion status clear");

    // R5 handshake disabled
    wr(12'h100, 32'h1111_0000);
    clkChgReq = 1'b1;
    tick(); tick(); tick();
    chk(clkChgAck == 1'b0, "R5 no acknowledge while disabled", 32'(clkChgAck), 32'h0);
    chk(act(0) == 32'hA5000000, "R5 active kept while disabled", act(0), 32'hA5000000);
    rd(12'h000, 32'h0, "R5 status untouched while disabled");
    clkChgReq = 1'b0;
    tick();

    // R4 R10 handshake with power-down mode
    wr(12'h2b8, 32'h3);
    rd(12'h2b8, 32'h3, "R11 config readback");
    clkChgReq = 1'b1;
    tick();
    chk(clkChgAck == 1'b1, "R4 acknowledge rises", 32'(clkChgAck), 32'h1);
    chk(act(0) == 32'h1111_0000, "R4 handshake copies shadows", act(0), 32'h1111_0000);
    chk(dramPowerDown && !dramSelfRefresh, "R10 power-down selected",
        32'({dramPowerDown, dramSelfRefresh}), 32'h2);
    rd(12'h000, 32'h10, "R4 completion status set");
    tick();
    chk(clkChgAck == 1'b1, "R4 acknowledge held", 32'(clkChgAck), 32'h1);
    clkChgReq = 1'b0;
    tick();
    chk(clkChgAck == 1'b0, "R4 acknowledge drops", 32'(clkChgAck), 32'h0);

    // R9 R7 mask and clear
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, 32'h18, "R9 mask keeps only bits 3 and 4");
    chk(irq == 1'b1, "R9 irq from completion", 32'(irq), 32'h1);
    wr(12'h000, 32'h0);
    rd(12'h000, 32'h10, "R7 writing zero keeps status");
    wr(12'h000, 32'h10);
    rd(12'h000, 32'h0, "R7 write-one clears status");
    chk(irq == 1'b0, "R9 irq clears", 32'(irq), 32'h0);

    // R8 refresh overflow, R7 set wins over clear
    refreshOverflow = 1'b1; tick(); refreshOverflow = 1'b0;
    rd(12'h000, 32'h08, "R8 overflow sets bit 3");
    wr(12'h004, 32'h10);
    chk(irq == 1'b0, "R9 masked overflow gives no irq", 32'(irq), 32'h0);
    refreshOverflow = 1'b1;
    wr(12'h000, 32'h08);
    refreshOverflow = 1'b0;
    rd(12'h000, 32'h08, "R7 set wins over same-cycle clear");
    wr(12'h000, 32'h08);
    rd(12'h000, 32'h0, "R7 overflow cleared");

    // R6 shadow write in the same cycle as a handshake
    wr(12'h2b8, 32'h7);
    wr(12'h114, 32'h0000_AAAA);
    wr(12'h028, 32'h1);
    clkChgReq = 1'b1;
    wr(12'h114, 32'h0000_BBBB);
    chk(act(5) == 32'h0000_AAAA, "R6 copy takes pre-write shadow", act(5), 32'h0000_AAAA);
    chk(dramSelfRefresh && !dramPowerDown, "R10 self-refresh has priority",
        32'({dramPowerDown, dramSelfRefresh}), 32'h1);
    clkChgReq = 1'b0;
    tick();
    wr(12'h000, 32'h18);

    // R6 flush and handshake in the same cycle
    wr(12'h118, 32'h0000_CCCC);
    clkChgReq = 1'b1;
    wr(12'h028, 32'h1);
    chk(act(5) == 32'h0000_BBBB && act(6) == 32'h0000_CCCC, "R6 single combined copy",
        act(6), 32'h0000_CCCC);
    rd(12'h000, 32'h10, "R6 completion status set once");
    clkChgReq = 1'b0;
    tick();

    // R11 unmapped accesses
    wr(12'h300, 32'hDEAD_BEEF);
    rd(12'h300, 32'h0, "R11 unmapped read is zero");
    rd(12'h00c, 32'h0, "R11 unmapped low read is zero");
    rd(12'h1b8, 32'h0, "R11 address past last word reads zero");
    rd(12'h102, 32'h0, "R11 misaligned read is zero");
    tick(); tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule